// File: doc/BRIEF.md
# Programmable Reference Divider with Prescaler

This block turns a stream of reference-clock enable events into a much slower comparison event. It runs in the system clock domain. Each cycle with `ref_en` high counts as one reference event. The events first pass through a prescaler whose ratio is picked from a fixed set of four values (1, 2, 10 or 100) by a 2-bit select. Every prescaler output event then feeds a programmable binary divider whose ratio comes from a 10-bit word. The overall ratio is the product of the two ratios. The divider can also be used on its own as a general programmable event divider.

Each time the binary stage completes a count, the block raises `div_out` for exactly one clock cycle. A ratio word of zero is not a forbidden value: it selects the largest binary ratio, 1024. Both stages take a new select or ratio value only when they complete a count, or while reset is held. A change made in the middle of a period therefore never produces a shortened or glitched period.

Top module: `refdiv_top`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, both counters clear and `div_out` is low after that edge. The first `div_out` pulse after reset comes after exactly P×N events, where P and N are the ratios sampled during reset.
- R2: The prescaler select `pre_sel` maps as follows: value 0 gives ÷1, 1 gives ÷2, 2 gives ÷10 and 3 gives ÷100.
- R3: For a `ratio_word` value N in the range 1 to 1023, the binary stage divides its input events by N.
- R4: A `ratio_word` of zero makes the binary stage divide by 1024.
- R5: The prescaler sits in front of the binary stage, so the spacing between `div_out` pulses is P×N reference events.
- R6: `div_out` is high for exactly one cycle per terminal count of the binary stage. It is high in the cycle after the clock edge that samples the completing `ref_en` event.
- R7: With both ratios equal to 1, every `ref_en` event yields a `div_out` pulse one cycle later, including on back-to-back events.
- R8: The prescaler samples `pre_sel` only at its own terminal count and during reset. The binary stage samples `ratio_word` only at its own terminal count and during reset. A change at any other time has no effect on the current period.
- R9: Cycles with `ref_en` low change neither counter, and `div_out` stays low during them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_en | input | 1 | One reference event per cycle when high |
| pre_sel | input | 2 | Prescaler select: 0 gives ÷1, 1 gives ÷2, 2 gives ÷10, 3 gives ÷100 |
| ratio_word | input | RATIO_W (10) | Binary ratio N; 0 means 1024 |
| div_out | output | 1 | One-cycle pulse at each binary terminal count |

## Verification
The bench builds the block with its default parameters: a 10-bit ratio word and prescaler ratios of 1, 2, 10 and 100. These defaults bring the 1024 encoding of a zero word and the ÷100 prescaler within reach of one run, at the cost of long periods. The bench therefore keeps those cases to a few periods and uses small ratio words and dense enable patterns for the random traffic. Its cycle-by-cycle reference model samples the select and the ratio only at modelled terminal counts. Mid-period changes, resets in the middle of a count and gaps in the enable stream are therefore all checked against the exact expected pulse positions.

// File: rtl/refdiv_pkg.sv
// Package refdiv_pkg
// Shared names for the reference divider: the prescaler select encoding
// and a helper that finds the largest prescaler ratio for sizing counters.
package refdiv_pkg;

    // Prescaler select encoding (the value driven on pre_sel)
    typedef enum logic [1:0] {
        PRE_DIV1   = 2'd0,
        PRE_DIV2   = 2'd1,
        PRE_DIV10  = 2'd2,
        PRE_DIV100 = 2'd3
    } pre_sel_e;

    // Largest of the four prescaler ratios; sizes the prescaler counter
    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/refdiv_prescale.sv
// Module refdiv_prescale
// Divides the incoming event stream by one of four fixed ratios picked by
// sel. The ratio in use is captured during reset and at each terminal
// count only, so a period already under way is never shortened.
// Assumes every ratio parameter is at least 1 and fits in CW bits.
// A ratio of 1 passes each input event straight through as a tick.
module refdiv_prescale
    import refdiv_pkg::*;
#(
    parameter int CW     = 7,
    parameter int RATIO0 = 1,
    parameter int RATIO1 = 2,
    parameter int RATIO2 = 10,
    parameter int RATIO3 = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_in,
    input  logic [1:0] sel,
    output logic       tick
);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] ratio_q;
    logic [CW-1:0] ratio_dec;
    logic          at_last;

    // Decode the select into a ratio value
    always_comb begin
        unique case (pre_sel_e'(sel))
            PRE_DIV1:   ratio_dec = CW'(RATIO0);
            PRE_DIV2:   ratio_dec = CW'(RATIO1);
            PRE_DIV10:  ratio_dec = CW'(RATIO2);
            default:    ratio_dec = CW'(RATIO3);
        endcase
    end

    // Terminal position of the current period
    assign at_last = (cnt_q == (ratio_q - CW'(1)));
    assign tick    = ev_in & at_last;

    // Count events; reload ratio at terminal count or in reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            ratio_q <= ratio_dec;
        end else if (ev_in) begin
            if (at_last) begin
                cnt_q   <= '0;
                ratio_q <= ratio_dec;
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    // R2
    pre_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < ratio_q);

    // R8
    pre_ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(ratio_q));

    // R9
    pre_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_in |=> $stable(cnt_q));

endmodule

// File: rtl/refdiv_binary.sv
// Module refdiv_binary
// Programmable divider over the prescaler ticks. A ratio word N from 1
// up to 2^W-1 divides by N; an all-zero word divides by 2^W. The word is
// captured during reset and at each terminal count only. The output is
// a registered one-cycle pulse after each completed count.
// Assumes tick_in is a single-cycle event qualifier.
module refdiv_binary #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_in,
    input  logic [W-1:0] ratio_word,
    output logic         pulse
);

    localparam int NW = W + 1;

    logic [W-1:0]  cnt_q;
    logic [NW-1:0] n_q;
    logic [NW-1:0] n_dec;
    logic          at_last;
    logic          term;
    logic          pulse_q;

    // Map an all-zero word to the full range 2^W
    assign n_dec   = (ratio_word == '0) ? (NW'(1) << W) : {1'b0, ratio_word};

    // Terminal position and terminal event
    assign at_last = ({1'b0, cnt_q} == (n_q - NW'(1)));
    assign term    = tick_in & at_last;

    // Count ticks; reload ratio at terminal count or in reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            n_q   <= n_dec;
        end else if (tick_in) begin
            if (at_last) begin
                cnt_q <= '0;
                n_q   <= n_dec;
            end else begin
                cnt_q <= cnt_q + W'(1);
            end
        end
    end

    // Register the output pulse; held low in reset
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= term;
    end

    assign pulse = pulse_q;

    // R3
    bin_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, cnt_q} < n_q);

    // R6
    bin_pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> $past(tick_in));

    // R8
    bin_ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !term |=> $stable(n_q));

    // R9
    bin_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_in |=> !pulse_q);

endmodule

// File: rtl/refdiv_top.sv
// Module refdiv_top
// Reference divider: a four-ratio prescaler followed by a programmable
// binary stage, giving one output pulse per P*N reference events.
// Assumes ref_en is a per-cycle event qualifier in the clk domain.
// When every prescaler ratio is 1 the prescaler is left out entirely.
module refdiv_top
    import refdiv_pkg::*;
#(
    parameter int RATIO_W = 10,
    parameter int PRE_R0  = 1,
    parameter int PRE_R1  = 2,
    parameter int PRE_R2  = 10,
    parameter int PRE_R3  = 100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ref_en,
    input  logic [1:0]         pre_sel,
    input  logic [RATIO_W-1:0] ratio_word,
    output logic               div_out
);

    localparam int PRE_MAX = max_of4(PRE_R0, PRE_R1, PRE_R2, PRE_R3);
    localparam int PRE_CW  = (PRE_MAX < 2) ? 1 : $clog2(PRE_MAX + 1);

    logic pre_tick;

    // Pick the prescaler variant from the ratio set
    generate
        if (PRE_MAX == 1) begin : g_no_pre
            assign pre_tick = ref_en;
        end else begin : g_pre
            refdiv_prescale #(
                .CW     (PRE_CW),
                .RATIO0 (PRE_R0),
                .RATIO1 (PRE_R1),
                .RATIO2 (PRE_R2),
                .RATIO3 (PRE_R3)
            ) u_pre (
                .clk   (clk),
                .rst_n (rst_n),
                .ev_in (ref_en),
                .sel   (pre_sel),
                .tick  (pre_tick)
            );
        end
    endgenerate

    refdiv_binary #(
        .W (RATIO_W)
    ) u_bin (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_in    (pre_tick),
        .ratio_word (ratio_word),
        .pulse      (div_out)
    );

    // R5
    top_tick_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pre_tick |-> ref_en);

    // R1
    top_reset_low_chk: assert property (@(posedge clk)
        !rst_n |=> !div_out);

endmodule

// File: tb/refdiv_top_tb.sv
// Bench for refdiv_top: directed corners plus seeded random traffic,
// every cycle compared against a reference model built from the brief.
module refdiv_top_tb;

    localparam int RW = 10;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ref_en;
    logic [1:0]    pre_sel;
    logic [RW-1:0] ratio_word;
    logic          div_out;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;
    string tag   = "R1";

    // Model state
    int  m_pcnt, m_pact, m_bcnt, m_nact;
    bit  m_out;
    int  pulses;

    always #4 clk = ~clk;   // 125 MHz

    refdiv_top #(.RATIO_W(RW)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_en     (ref_en),
        .pre_sel    (pre_sel),
        .ratio_word (ratio_word),
        .div_out    (div_out)
    );

    function automatic int pre_ratio(input logic [1:0] s);
        case (s)
            2'd0: return 1;
            2'd1: return 2;
            2'd2: return 10;
            default: return 100;
        endcase
    endfunction

    function automatic int bin_ratio(input logic [RW-1:0] w);
        return (w == 0) ? 1024 : int'(w);
    endfunction

    task automatic check_out();
        checks++;
        if (div_out !== m_out) begin
            failures++;
            $display("FAIL %s: div_out=%0b expected=%0b at cycle %0d", tag, div_out, m_out, cycles);
        end
        if (m_out) pulses++;
    endtask

    // One cycle: check current output, drive inputs, advance the model
    task automatic step(input bit rn, input bit en, input logic [1:0] s, input logic [RW-1:0] w);
        @(negedge clk);
        check_out();
        rst_n = rn; ref_en = en; pre_sel = s; ratio_word = w;
        if (!rn) begin
            m_pcnt = 0; m_bcnt = 0; m_out = 0;
            m_pact = pre_ratio(s); m_nact = bin_ratio(w);
        end else begin
            m_out = 0;
            if (en) begin
                m_pcnt++;
                if (m_pcnt == m_pact) begin
                    m_pcnt = 0;
                    m_pact = pre_ratio(s);
                    m_bcnt++;
                    if (m_bcnt == m_nact) begin
                        m_bcnt = 0;
                        m_nact = bin_ratio(w);
                        m_out  = 1;
                    end
                end
            end
        end
        cycles++;
    endtask

    task automatic do_reset(input logic [1:0] s, input logic [RW-1:0] w);
        step(1'b0, 1'b0, s, w);
        step(1'b0, 1'b0, s, w);
    endtask

    // Run a number of events at full rate and count model pulses
    task automatic run(input int n, input logic [1:0] s, input logic [RW-1:0] w);
        for (int i = 0; i < n; i++) step(1'b1, 1'b1, s, w);
    endtask

    task automatic expect_pulses(input int got, input int exp_n, input string t);
        checks++;
        if (got != exp_n) begin
            failures++;
            $display("FAIL %s: pulse count=%0d expected=%0d", t, got, exp_n);
        end
    endtask

    initial begin
        int base;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; ref_en = 1'b0; pre_sel = 2'd0; ratio_word = '0;
        m_pcnt = 0; m_pact = 1; m_bcnt = 0; m_nact = 1024; m_out = 0; pulses = 0;

        // R1: reset state
        tag = "R1";
        do_reset(2'd1, 10'd3);
        @(negedge clk);
        checks++;
        if (div_out !== 1'b0) begin
            failures++;
            $display("FAIL R1: div_out=%0b expected=0 after reset", div_out);
        end

        // R7: pass-through with both ratios 1, back-to-back
        tag = "R7";
        do_reset(2'd0, 10'd1);
        base = pulses; run(20, 2'd0, 10'd1); step(1'b1, 1'b0, 2'd0, 10'd1);
        expect_pulses(pulses - base, 20, "R7");

        // R2/R5: each prescaler ratio with N=3
        for (int s = 0; s < 4; s++) begin
            tag = "R2";
            do_reset(2'(s), 10'd3);
            base = pulses;
            run(pre_ratio(2'(s)) * 3 * 2, 2'(s), 10'd3);
            step(1'b1, 1'b0, 2'(s), 10'd3);
            expect_pulses(pulses - base, 2, "R2 R5");
        end

        // R3: binary ratios incl. 1023
        tag = "R3";
        do_reset(2'd0, 10'd1023);
        base = pulses; run(1023 * 2, 2'd0, 10'd1023); step(1'b1, 1'b0, 2'd0, 10'd1023);
        expect_pulses(pulses - base, 2, "R3");

        // R4: zero word means 1024
        tag = "R4";
        do_reset(2'd0, 10'd0);
        base = pulses; run(1023, 2'd0, 10'd0); step(1'b1, 1'b0, 2'd0, 10'd0);
        expect_pulses(pulses - base, 0, "R4 early");
        run(1, 2'd0, 10'd0); step(1'b1, 1'b0, 2'd0, 10'd0);
        expect_pulses(pulses - base, 1, "R4");

        // R5: x100 with zero word, one period
        tag = "R5";
        do_reset(2'd3, 10'd0);
        base = pulses; run(102400, 2'd3, 10'd0); step(1'b1, 1'b0, 2'd3, 10'd0);
        expect_pulses(pulses - base, 1, "R5");

        // R8: mid-period changes only apply after terminal count
        tag = "R8";
        do_reset(2'd1, 10'd5);
        run(3, 2'd1, 10'd5);
        run(30, 2'd2, 10'd2);
        run(20, 2'd0, 10'd7);

        // R1: reset in the middle of a count
        tag = "R1";
        run(4, 2'd1, 10'd4);
        do_reset(2'd1, 10'd4);
        base = pulses; run(8, 2'd1, 10'd4); step(1'b1, 1'b0, 2'd1, 10'd4);
        expect_pulses(pulses - base, 1, "R1 first pulse");

        // R9: long idle gaps
        tag = "R9";
        for (int i = 0; i < 40; i++) step(1'b1, 1'b0, 2'd0, 10'd1);

        // R6: random traffic with random enable density and ratio changes
        tag = "R6";
        do_reset(2'd1, 10'd4);
        for (int i = 0; i < 8000; i++) begin
            logic [1:0]    s;
            logic [RW-1:0] w;
            s = ($urandom % 8 == 0) ? 2'($urandom % 3) : pre_sel;
            w = ($urandom % 16 == 0) ? RW'(1 + $urandom % 12) : ratio_word;
            step(1'b1, ($urandom % 4) != 0, s, w);
        end
        step(1'b1, 1'b0, pre_sel, ratio_word);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        #(8 * 190000);
        failures++;
        $display("FAIL watchdog: cycles=%0d expected completion", cycles);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule